// File: doc/BRIEF.md
# Clock Generator Start-up Strap Sequencer

This block brings a clock generator from power-off to running outputs in a fixed order. Once the analog supply is valid it waits a settling interval. It then waits for the active-low termination-rail good input. At the first low level of that input it captures the frequency-select and drive-multiplier strap pins. It keeps those captured values for the rest of the power cycle and ignores the good input from then on. After capture it turns the PLL on, counts a lock interval and then opens the per-output enables.

The power-down input is asynchronous and active-low. A synchroniser brings it into the clock domain. While it is asserted, the PLL enable drops and every output enable closes on the same cycle. When power-down is released, the same lock timer runs again before the outputs reopen. Each output's enable opens only while that output's clock phase input is low, so no output emits a shortened first pulse. If the supply indication is lost, the sequencer returns to the off state from anywhere.

Top module: `clkgen_startup_seq`

## Requirements
- R1: During reset, state_o is 0, pll_en and out_en are all zero, and latched_fsel and latched_mult are zero.
- R2: The state encoding is off=0, settle=1, sample=2, run=3. Supply_ok high in the off state moves to settle on the next edge. The settle state then lasts exactly SETTLE_CYC clock cycles before the sample state is entered.
- R3: In the sample state, the first edge that sees vtt_good_n low captures strap_fsel and strap_mult into latched_fsel and latched_mult and moves to run.
- R4: While vtt_good_n stays high in the sample state, the state remains 2 and strap pin changes are not captured.
- R5: In the run state, toggles of vtt_good_n and changes of the strap pins change neither the latched values nor the state.
- R6: pll_en is high only in the run state while power-down is not in effect after synchronisation.
- R7: The outputs unlock LOCK_CYC cycles after run is entered. Bit i of out_en then rises at the first later edge that samples out_phase[i] low, and it stays high.
- R8: pwrdn_n passes through SYNC_STAGES flops before use. pll_en falls SYNC_STAGES edges after pwrdn_n falls, and all of out_en clears together at the following edge.
- R9: After pwrdn_n is released, the full LOCK_CYC wait repeats before any enable reopens, and the latched strap values are kept.
- R10: Supply_ok low in any state gives state 0 with pll_en and out_en low at the next edge. A new power-up repeats the full settle count and recaptures the straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| supply_ok | input | 1 | Analog supply above valid threshold (synchronous) |
| vtt_good_n | input | 1 | Active-low termination-rail good strobe |
| strap_fsel | input | FSEL_W | Frequency-select strap pins |
| strap_mult | input | MULT_W | Drive-current multiplier strap pins |
| pwrdn_n | input | 1 | Asynchronous active-low power-down |
| out_phase | input | NUM_OUT | Current level of each output clock |
| latched_fsel | output | FSEL_W | Captured frequency-select value |
| latched_mult | output | MULT_W | Captured multiplier value |
| pll_en | output | 1 | PLL power/run enable |
| out_en | output | NUM_OUT | Per-output clock enable |
| state_o | output | 2 | Sequencer state |

## Verification
The bench walks every state transition with a short settle and lock count. It checks each cycle boundary of the settle interval against the configured count, which exposes any off-by-one. Phase inputs are driven from a binary counter, so each output bit sees a different low-phase schedule. This separates per-output release from a common release. An all-low phase pattern after power-down pins the exact reopen cycle. Strap and good-strobe toggles during run separate a one-time capture from a level-following latch. A supply drop part-way through settling shows that the timer restarts from zero.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [1:0] {
      SQ_OFF    = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_SAMPLE = 2'd2,
      SQ_RUN    = 2'd3
   } seq_state_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkseq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run && !done) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/clkseq_out_gate.sv
module clkseq_out_gate #(
   parameter int unsigned NUM_OUT        = 8,
   parameter bit          RELEASE_ON_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               allow,
   input  logic [NUM_OUT-1:0] phase,
   output logic [NUM_OUT-1:0] en
);

   generate
      if (RELEASE_ON_LOW) begin : g_phase_aligned
         for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  en[gi] <= 1'b0;
               end else if (!allow) begin
                  en[gi] <= 1'b0;
               end else if (!phase[gi]) begin
                  en[gi] <= 1'b1;
               end
            end
         end
      end else begin : g_immediate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en <= '0;
            end else begin
               en <= {NUM_OUT{allow}};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/clkgen_startup_seq.sv
module clkgen_startup_seq
   import clkseq_pkg::*;
#(
   parameter int unsigned FSEL_W         = 5,
   parameter int unsigned MULT_W         = 2,
   parameter int unsigned NUM_OUT        = 8,
   parameter int unsigned SETTLE_CYC     = 9000,
   parameter int unsigned LOCK_CYC       = 38000,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          RELEASE_ON_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               supply_ok,
   input  logic               vtt_good_n,
   input  logic [FSEL_W-1:0]  strap_fsel,
   input  logic [MULT_W-1:0]  strap_mult,
   input  logic               pwrdn_n,
   input  logic [NUM_OUT-1:0] out_phase,
   output logic [FSEL_W-1:0]  latched_fsel,
   output logic [MULT_W-1:0]  latched_mult,
   output logic               pll_en,
   output logic [NUM_OUT-1:0] out_en,
   output logic [1:0]         state_o
);

   localparam int unsigned CNT_MAX = max_of(SETTLE_CYC, LOCK_CYC);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] SETTLE_L = CNT_W'(SETTLE_CYC);
   localparam logic [CNT_W-1:0] LOCK_L   = CNT_W'(LOCK_CYC);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("clkgen_startup_seq: SETTLE_CYC must be at least 1");
      end
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("clkgen_startup_seq: LOCK_CYC must be at least 1");
      end
      if (NUM_OUT < 1) begin : g_bad_nout
         $error("clkgen_startup_seq: NUM_OUT must be at least 1");
      end
      if (FSEL_W < 1 || MULT_W < 1) begin : g_bad_strap
         $error("clkgen_startup_seq: strap widths must be at least 1");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic              locked_q, locked_d;
   logic              pd_n_sync, pd_act;
   logic              capture;
   logic              tmr_clr, tmr_run, tmr_done;
   logic [CNT_W-1:0]  tmr_limit;
   logic              gate_allow;
   logic [FSEL_W-1:0] fsel_q;
   logic [MULT_W-1:0] mult_q;

   // power-down synchroniser, resets to the asserted level
   clkseq_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b0)
   ) u_pd_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pwrdn_n),
      .q    (pd_n_sync)
   );

   assign pd_act  = !pd_n_sync;
   assign capture = (state_q == SQ_SAMPLE) && supply_ok && !vtt_good_n;

   // next-state logic
   always_comb begin
      state_d = state_q;
      if (!supply_ok) begin
         state_d = SQ_OFF;
      end else begin
         unique case (state_q)
            SQ_OFF:    state_d = SQ_SETTLE;
            SQ_SETTLE: if (tmr_done) state_d = SQ_SAMPLE;
            SQ_SAMPLE: if (capture) state_d = SQ_RUN;
            SQ_RUN:    state_d = SQ_RUN;
            default:   state_d = SQ_OFF;
         endcase
      end
   end

   // shared timer: settle count in settle state, lock count in run state
   assign tmr_limit = (state_q == SQ_SETTLE) ? SETTLE_L : LOCK_L;
   assign tmr_run   = (state_q == SQ_SETTLE) ||
                      ((state_q == SQ_RUN) && !pd_act && !locked_q);
   assign tmr_clr   = (state_q != state_d) ||
                      (state_q == SQ_OFF) ||
                      (state_q == SQ_SAMPLE) ||
                      ((state_q == SQ_RUN) && pd_act);

   clkseq_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (tmr_clr),
      .run  (tmr_run),
      .limit(tmr_limit),
      .done (tmr_done)
   );

   always_comb begin
      locked_d = locked_q;
      if ((state_q != SQ_RUN) || !supply_ok || pd_act) begin
         locked_d = 1'b0;
      end else if (tmr_run && tmr_done) begin
         locked_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_OFF;
         locked_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         locked_q <= locked_d;
      end
   end

   // one-time strap capture per power cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsel_q <= '0;
         mult_q <= '0;
      end else if (capture) begin
         fsel_q <= strap_fsel;
         mult_q <= strap_mult;
      end
   end

   assign gate_allow = locked_q && !pd_act && supply_ok && (state_q == SQ_RUN);

   clkseq_out_gate #(
      .NUM_OUT       (NUM_OUT),
      .RELEASE_ON_LOW(RELEASE_ON_LOW)
   ) u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .allow(gate_allow),
      .phase(out_phase),
      .en   (out_en)
   );

   assign pll_en       = (state_q == SQ_RUN) && !pd_act;
   assign latched_fsel = fsel_q;
   assign latched_mult = mult_q;
   assign state_o      = state_q;

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk #(
   parameter int unsigned FSEL_W         = 5,
   parameter int unsigned MULT_W         = 2,
   parameter int unsigned NUM_OUT        = 8,
   parameter bit          RELEASE_ON_LOW = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               supply_ok,
   input logic               vtt_good_n,
   input logic [FSEL_W-1:0]  strap_fsel,
   input logic [MULT_W-1:0]  strap_mult,
   input logic [NUM_OUT-1:0] out_phase,
   input logic [FSEL_W-1:0]  latched_fsel,
   input logic [MULT_W-1:0]  latched_mult,
   input logic               pll_en,
   input logic [NUM_OUT-1:0] out_en,
   input logic [1:0]         state_o
);

   AST_IDLE_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (state_o == 2'd0 && out_en == '0)); // R10

   AST_SETTLE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && supply_ok) |=> (state_o == 2'd1)); // R2

   AST_CAPTURE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && supply_ok && !vtt_good_n) |=>
      (state_o == 2'd3 && latched_fsel == $past(strap_fsel) &&
       latched_mult == $past(strap_mult))); // R3

   AST_HOLD_UNTIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && supply_ok && vtt_good_n) |=>
      (state_o == 2'd2 && $stable(latched_fsel))); // R4

   AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3 && supply_ok) |=>
      (state_o == 2'd3 && $stable(latched_fsel) && $stable(latched_mult))); // R5

   AST_PLL_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |-> (state_o == 2'd3)); // R6

   AST_GATE_FOLLOWS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |=> (out_en == '0)); // R8

   generate
      if (RELEASE_ON_LOW) begin : g_phase_chk
         for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_bit
            AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
               (!out_en[gi] && out_phase[gi]) |=> !out_en[gi]); // R7
         end
      end
   endgenerate

endmodule

bind clkgen_startup_seq clkseq_chk #(
   .FSEL_W        (FSEL_W),
   .MULT_W        (MULT_W),
   .NUM_OUT       (NUM_OUT),
   .RELEASE_ON_LOW(RELEASE_ON_LOW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .supply_ok   (supply_ok),
   .vtt_good_n  (vtt_good_n),
   .strap_fsel  (strap_fsel),
   .strap_mult  (strap_mult),
   .out_phase   (out_phase),
   .latched_fsel(latched_fsel),
   .latched_mult(latched_mult),
   .pll_en      (pll_en),
   .out_en      (out_en),
   .state_o     (state_o)
);

// File: tb/clkgen_startup_seq_tb.sv
module clkgen_startup_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int FW  = 5;
   localparam int MW  = 2;
   localparam int NO  = 4;
   localparam int SET = 5;
   localparam int LCK = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          supply_ok = 1'b0;
   logic          vtt_good_n = 1'b1;
   logic          pwrdn_n = 1'b1;
   logic [FW-1:0] strap_fsel = '0;
   logic [MW-1:0] strap_mult = '0;
   logic [NO-1:0] out_phase = '1;
   logic [FW-1:0] latched_fsel;
   logic [MW-1:0] latched_mult;
   logic          pll_en;
   logic [NO-1:0] out_en;
   logic [1:0]    state_o;

   int n_chk  = 0;
   int n_fail = 0;

   clkgen_startup_seq #(
      .FSEL_W(FW), .MULT_W(MW), .NUM_OUT(NO),
      .SETTLE_CYC(SET), .LOCK_CYC(LCK), .SYNC_STAGES(2), .RELEASE_ON_LOW(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vtt_good_n(vtt_good_n),
      .strap_fsel(strap_fsel), .strap_mult(strap_mult), .pwrdn_n(pwrdn_n),
      .out_phase(out_phase), .latched_fsel(latched_fsel), .latched_mult(latched_mult),
      .pll_en(pll_en), .out_en(out_en), .state_o(state_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drives phases, models per-output release after (offset + LCK) edges
   task automatic lock_run(input int offset, input int span, input bit zero_phase,
                           input bit toggle_pins, input string tag);
      logic [NO-1:0] exp_en = '0;
      logic [7:0]    ph = 8'd0;
      for (int t = 1; t <= span; t++) begin
         logic [NO-1:0] used;
         used = zero_phase ? '0 : ph[NO-1:0];
         out_phase = used;
         ph = ph + 8'd1;
         if (toggle_pins) begin
            vtt_good_n = ~vtt_good_n;
            strap_fsel = strap_fsel + 1'b1;
            strap_mult = ~strap_mult;
         end
         tick(1);
         if (t > offset + LCK) exp_en = exp_en | ~used;
         chk(out_en == exp_en, tag, out_en, exp_en);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      tick(3);
      chk(state_o == 2'd0, "R1 state", state_o, 0);
      chk(pll_en == 1'b0 && out_en == '0, "R1 enables", {pll_en, out_en}, 0);
      chk(latched_fsel == '0 && latched_mult == '0, "R1 latched", {latched_fsel, latched_mult}, 0);
      rst_n = 1'b1;
      tick(2);
      chk(state_o == 2'd0, "R2 idle without supply", state_o, 0);

      // R2 settle length
      supply_ok = 1'b1;
      for (int k = 1; k <= SET; k++) begin
         tick(1);
         chk(state_o == 2'd1, "R2 settle", state_o, 1);
      end
      tick(1);
      chk(state_o == 2'd2, "R2 enter sample", state_o, 2);

      // R4 no capture while good strobe high
      for (int k = 0; k < 6; k++) begin
         strap_fsel = FW'(k + 3);
         strap_mult = MW'(k);
         tick(1);
         chk(state_o == 2'd2, "R4 hold sample", state_o, 2);
         chk(latched_fsel == '0, "R4 no capture", latched_fsel, 0);
         chk(pll_en == 1'b0, "R6 pll off in sample", pll_en, 0);
      end

      // R3 capture
      strap_fsel = 5'h13;
      strap_mult = 2'b10;
      vtt_good_n = 1'b0;
      tick(1);
      chk(state_o == 2'd3, "R3 enter run", state_o, 3);
      chk(latched_fsel == 5'h13, "R3 fsel", latched_fsel, 5'h13);
      chk(latched_mult == 2'b10, "R3 mult", latched_mult, 2'b10);
      chk(pll_en == 1'b1, "R6 pll on in run", pll_en, 1);

      // R7 lock wait and per-output release; R5 pins toggling meanwhile
      lock_run(0, LCK + 12, 1'b0, 1'b1, "R7 release");
      chk(out_en == '1, "R7 all open", out_en, 4'hF);
      chk(latched_fsel == 5'h13 && latched_mult == 2'b10, "R5 straps frozen",
          {latched_fsel, latched_mult}, {5'h13, 2'b10});
      chk(state_o == 2'd3, "R5 state held", state_o, 3);

      // R8 power-down through synchroniser
      pwrdn_n = 1'b0;
      tick(1);
      chk(pll_en == 1'b1 && out_en == '1, "R8 stage1", {pll_en, out_en}, 5'h1F);
      tick(1);
      chk(pll_en == 1'b0, "R8 pll off", pll_en, 0);
      chk(out_en == '1, "R8 enables one later", out_en, 4'hF);
      tick(1);
      chk(out_en == '0, "R8 all closed together", out_en, 0);
      tick(5);
      chk(out_en == '0 && pll_en == 1'b0, "R8 held off", {pll_en, out_en}, 0);
      chk(state_o == 2'd3, "R8 state kept", state_o, 3);

      // R9 release: lock wait repeats
      pwrdn_n = 1'b1;
      lock_run(2, LCK + 6, 1'b1, 1'b0, "R9 relock");
      chk(pll_en == 1'b1, "R9 pll on", pll_en, 1);
      chk(latched_fsel == 5'h13 && latched_mult == 2'b10, "R9 straps kept",
          {latched_fsel, latched_mult}, {5'h13, 2'b10});

      // R10 supply loss from run
      supply_ok = 1'b0;
      tick(1);
      chk(state_o == 2'd0, "R10 off", state_o, 0);
      chk(pll_en == 1'b0 && out_en == '0, "R10 enables low", {pll_en, out_en}, 0);

      // R10 loss part-way through settle restarts the count
      supply_ok = 1'b1;
      tick(3);
      chk(state_o == 2'd1, "R10 settle again", state_o, 1);
      supply_ok = 1'b0;
      tick(1);
      chk(state_o == 2'd0, "R10 loss in settle", state_o, 0);
      supply_ok = 1'b1;
      vtt_good_n = 1'b0;
      strap_fsel = 5'h0A;
      strap_mult = 2'b01;
      for (int k = 1; k <= SET; k++) begin
         tick(1);
         chk(state_o == 2'd1, "R10 full settle", state_o, 1);
      end
      tick(1);
      chk(state_o == 2'd2, "R10 sample", state_o, 2);
      tick(1);
      chk(state_o == 2'd3, "R10 run", state_o, 3);
      chk(latched_fsel == 5'h0A && latched_mult == 2'b01, "R10 recapture",
          {latched_fsel, latched_mult}, {5'h0A, 2'b01});

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule